// File: doc/BRIEF.md
# Paged-Jump Program Counter

This block holds the instruction address of a 16-bit word machine whose memory is addressed in bytes. The address is kept in two parts: a word counter for all bits above bit 0, and a separate single-bit register for bit 0. Sequential fetch therefore moves the address forward by one 16-bit word, which is two bytes, and bit 0 is never touched by counting. The fetch address given to memory is the same address with bit 0 forced low, so an instruction fetch is always word-aligned.

Control flow can change in two ways. A short jump carries an 8-bit word offset. It keeps the page bits of the current address, which select a 256-word page, and replaces only the word index within that page. It cannot leave the current page. A long jump takes two instruction words. In the first cycle the upper address bits come from the first word, the counter steps onto the extension word, and a pending flag is raised. In the next cycle the 16-bit extension word supplies the low address bits, and the full byte address is loaded. The long form reaches the whole 8 MB space at the cost of one extra clock.

Top module: `pc_paged_jump`

## Requirements
- R1: While reset is active, and in the first cycle after reset is released, the address is 0, the fetch address is 0 and the pending flag is low.
- R2: With `step_i` high and no jump request, the byte address grows by 2 in the next cycle and bit 0 keeps its value. With no request at all, the address holds.
- R3: A short jump (`near_i` high) keeps address bits 22..9 (the page), loads bits 8..1 with `near_off_i`, and clears bit 0, all in the next cycle.
- R4: In the cycle after a long jump request (`far_i` high while the pending flag is low), the address has grown by 2 and `far_pend_o` is high for exactly one cycle.
- R5: In the cycle after a pending cycle, the address equals {`far_hi_i` as sampled with the request (bits 22..16), `ext_word_i` as sampled in the pending cycle (bits 15..0)}, with bit 0 taken from `ext_word_i[0]`, and the pending flag is low.
- R6: The long jump request takes priority over a short jump, and a short jump takes priority over stepping. While the flag is pending, `step_i`, `near_i` and `far_i` have no effect.
- R7: `fetch_addr_o` always equals the address with bit 0 forced to 0.
- R8: Stepping from the highest word wraps the word part to 0 and keeps bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously inside the block |
| step_i | input | 1 | Advance by one word |
| near_i | input | 1 | Short in-page jump request |
| near_off_i | input | 8 | Word offset within the current page |
| far_i | input | 1 | Long jump request (first word) |
| far_hi_i | input | 7 | Upper address bits from the first word |
| ext_word_i | input | 16 | Extension word, used in the pending cycle |
| pc_o | output | 23 | Byte address, including bit 0 |
| fetch_addr_o | output | 23 | Word-aligned fetch address |
| far_pend_o | output | 1 | Extension word fetch pending |

## Verification
The bench sweeps every short-jump offset over several pages, including the top and bottom page, to check that the page bits survive. A design that carried into the page or dropped the offset's top bit would land in the wrong page. Long jumps go to odd and even targets, then step. This catches a counter that swallows bit 0 and so turns odd addresses even, or that adds 1 instead of 2. Requests are also driven together and during the pending cycle, which catches a wrong priority order or a pending cycle that lets a new jump overwrite the target. A wrap from the top word catches a counter that lets the carry spill into bit 0.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD   = 3'd0,
    ACT_STEP   = 3'd1,
    ACT_NEAR   = 3'd2,
    ACT_FARBEG = 3'd3,
    ACT_FARLD  = 3'd4
  } pc_act_e;
endpackage

// File: rtl/pc_rst_sync.sv
module pc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/pc_word_ctr.sv
module pc_word_ctr #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_en,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         q_en;

  always_comb begin
    q_en  = inc_en | ld_en;
    q_nxt = ld_en ? ld_val : q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/pc_bit0_reg.sv
module pc_bit0_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_en,
  input  logic ld_val,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (ld_en) q <= ld_val;
  end
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import pc_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int OFF_W  = 8,
  parameter int EXT_W  = 16,
  localparam int WRD_W = ADDR_W - 1,
  localparam int HI_W  = ADDR_W - EXT_W
) (
  input  logic             pend,
  input  logic             step,
  input  logic             near,
  input  logic             far,
  input  logic [OFF_W-1:0] near_off,
  input  logic [HI_W-1:0]  hi_held,
  input  logic [EXT_W-1:0] ext_word,
  input  logic [WRD_W-1:0] word_q,
  output pc_act_e          act,
  output logic             ctr_inc,
  output logic             ctr_ld,
  output logic [WRD_W-1:0] ctr_val,
  output logic             b0_ld,
  output logic             b0_val,
  output logic             hi_ld,
  output logic             pend_nxt
);
  logic [ADDR_W-1:0] far_tgt;

  always_comb begin
    far_tgt = {hi_held, ext_word};
    if (pend)      act = ACT_FARLD;
    else if (far)  act = ACT_FARBEG;
    else if (near) act = ACT_NEAR;
    else if (step) act = ACT_STEP;
    else           act = ACT_HOLD;

    ctr_inc  = 1'b0;
    ctr_ld   = 1'b0;
    ctr_val  = far_tgt[ADDR_W-1:1];
    b0_ld    = 1'b0;
    b0_val   = 1'b0;
    hi_ld    = 1'b0;
    pend_nxt = 1'b0;
    unique case (act)
      ACT_STEP:   ctr_inc = 1'b1;
      ACT_NEAR: begin
        ctr_ld  = 1'b1;
        ctr_val = {word_q[WRD_W-1:OFF_W], near_off};
        b0_ld   = 1'b1;
        b0_val  = 1'b0;
      end
      ACT_FARBEG: begin
        ctr_inc  = 1'b1;
        hi_ld    = 1'b1;
        pend_nxt = 1'b1;
      end
      ACT_FARLD: begin
        ctr_ld  = 1'b1;
        ctr_val = far_tgt[ADDR_W-1:1];
        b0_ld   = 1'b1;
        b0_val  = far_tgt[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pc_paged_jump.sv
module pc_paged_jump
  import pc_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int OFF_W  = 8,
  parameter int EXT_W  = 16,
  localparam int WRD_W = ADDR_W - 1,
  localparam int HI_W  = ADDR_W - EXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              near_i,
  input  logic [OFF_W-1:0]  near_off_i,
  input  logic              far_i,
  input  logic [HI_W-1:0]   far_hi_i,
  input  logic [EXT_W-1:0]  ext_word_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              far_pend_o
);
  logic             rst_q_n;
  logic [WRD_W-1:0] word_q;
  logic             b0_q;
  logic [HI_W-1:0]  hi_q;
  logic             pend_q;
  pc_act_e          act;
  logic             ctr_inc, ctr_ld, b0_ld, b0_val, hi_ld, pend_nxt;
  logic [WRD_W-1:0] ctr_val;

  pc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  pc_next_sel #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .EXT_W(EXT_W)) u_sel (
    .pend(pend_q), .step(step_i), .near(near_i), .far(far_i),
    .near_off(near_off_i), .hi_held(hi_q), .ext_word(ext_word_i),
    .word_q(word_q), .act(act), .ctr_inc(ctr_inc), .ctr_ld(ctr_ld),
    .ctr_val(ctr_val), .b0_ld(b0_ld), .b0_val(b0_val), .hi_ld(hi_ld),
    .pend_nxt(pend_nxt)
  );

  pc_word_ctr #(.W(WRD_W)) u_ctr (
    .clk(clk), .rst_n(rst_q_n), .inc_en(ctr_inc), .ld_en(ctr_ld),
    .ld_val(ctr_val), .q(word_q)
  );

  pc_bit0_reg u_b0 (
    .clk(clk), .rst_n(rst_q_n), .ld_en(b0_ld), .ld_val(b0_val), .q(b0_q)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)   hi_q <= '0;
    else if (hi_ld) hi_q <= far_hi_i;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) pend_q <= 1'b0;
    else          pend_q <= pend_nxt;
  end

  assign pc_o         = {word_q, b0_q};
  assign fetch_addr_o = {word_q, 1'b0};
  assign far_pend_o   = pend_q;
endmodule

// File: rtl/pc_paged_jump_chk.sv
module pc_paged_jump_chk #(
  parameter int ADDR_W = 23,
  parameter int OFF_W  = 8,
  parameter int EXT_W  = 16,
  localparam int HI_W  = ADDR_W - EXT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_i,
  input logic              near_i,
  input logic [OFF_W-1:0]  near_off_i,
  input logic              far_i,
  input logic [HI_W-1:0]   far_hi_i,
  input logic [EXT_W-1:0]  ext_word_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              far_pend_o
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !near_i && !far_i && !far_pend_o) |=>
      (pc_o[ADDR_W-1:1] == $past(pc_o[ADDR_W-1:1]) + 1'b1) && (pc_o[0] == $past(pc_o[0])));

  p_near_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (near_i && !far_i && !far_pend_o) |=>
      (pc_o[ADDR_W-1:OFF_W+1] == $past(pc_o[ADDR_W-1:OFF_W+1])) &&
      (pc_o[OFF_W:1] == $past(near_off_i)) && !pc_o[0]);

  p_pend_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (far_i && !far_pend_o) |=> far_pend_o);

  p_pend_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    far_pend_o |=> !far_pend_o);

  p_far_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    far_pend_o |=> (pc_o == {$past(far_hi_i, 2), $past(ext_word_i)}));

  p_fetch_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr_o[0] == 1'b0) && (fetch_addr_o[ADDR_W-1:1] == pc_o[ADDR_W-1:1]));
endmodule

bind pc_paged_jump pc_paged_jump_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .EXT_W(EXT_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .step_i(step_i), .near_i(near_i),
  .near_off_i(near_off_i), .far_i(far_i), .far_hi_i(far_hi_i),
  .ext_word_i(ext_word_i), .pc_o(pc_o), .fetch_addr_o(fetch_addr_o),
  .far_pend_o(far_pend_o)
);

// File: tb/sim_pc_paged_jump.sv
`timescale 1ns/1ps
module sim_pc_paged_jump;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i, near_i, far_i;
  logic [7:0]  near_off_i;
  logic [6:0]  far_hi_i;
  logic [15:0] ext_word_i;
  logic [22:0] pc_o, fetch_addr_o;
  logic        far_pend_o;

  int checks = 0;
  int failures = 0;
  logic [22:0] exp_pc;
  logic        exp_pend;
  logic [6:0]  exp_hi;
  bit          done = 0;

  always #2 clk = ~clk;

  pc_paged_jump u0 (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .near_i(near_i),
    .near_off_i(near_off_i), .far_i(far_i), .far_hi_i(far_hi_i),
    .ext_word_i(ext_word_i), .pc_o(pc_o), .fetch_addr_o(fetch_addr_o),
    .far_pend_o(far_pend_o)
  );

  task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive, update the model from the requirements, compare.
  task automatic cyc(input logic st, input logic nr, input logic [7:0] off,
                     input logic fr, input logic [6:0] hi, input logic [15:0] ext,
                     input string req);
    step_i = st; near_i = nr; near_off_i = off; far_i = fr;
    far_hi_i = hi; ext_word_i = ext;
    @(posedge clk);
    if (exp_pend) begin
      exp_pc   = {exp_hi, ext};
      exp_pend = 1'b0;
    end else if (fr) begin
      exp_pc   = {exp_pc[22:1] + 22'd1, exp_pc[0]};
      exp_hi   = hi;
      exp_pend = 1'b1;
    end else if (nr) begin
      exp_pc = {exp_pc[22:9], off, 1'b0};
    end else if (st) begin
      exp_pc = {exp_pc[22:1] + 22'd1, exp_pc[0]};
    end
    @(negedge clk);
    check(req, pc_o, exp_pc);
    check({req, "/pend"}, {22'd0, far_pend_o}, {22'd0, exp_pend});
    check("R7", fetch_addr_o, {exp_pc[22:1], 1'b0});
  endtask

  task automatic far_jump(input logic [22:0] tgt, input string req);
    cyc(1'b1, 1'b0, 8'h00, 1'b1, tgt[22:16], 16'h0000, "R4");
    cyc(1'b1, 1'b1, 8'h5A, 1'b1, 7'h00, tgt[15:0], req);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step_i = 0; near_i = 0; far_i = 0;
    near_off_i = 0; far_hi_i = 0; ext_word_i = 0;
    exp_pc = '0; exp_pend = 0; exp_hi = '0;
    repeat (2) @(negedge clk);
    step_i = 1; near_i = 1; far_i = 1;
    @(negedge clk);
    check("R1", pc_o, 23'd0);
    check("R1", {22'd0, far_pend_o}, 23'd0);
    check("R1", fetch_addr_o, 23'd0);
    step_i = 0; near_i = 0; far_i = 0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", pc_o, 23'd0);
    check("R1", {22'd0, far_pend_o}, 23'd0);

    // R2: stepping and holding
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 8'h00, 1'b0, 7'h00, 16'h0, "R2");
    for (int i = 0; i < 4; i++)  cyc(1'b0, 1'b0, 8'hFF, 1'b0, 7'h7F, 16'hFFFF, "R2");

    // R3: every offset across several pages, including top and bottom page
    for (int p = 0; p < 4; p++) begin
      logic [22:0] base;
      base = (p == 0) ? 23'h000000 : (p == 1) ? 23'h7FFE01 : (p == 2) ? 23'h2A5401 : 23'h55AB00;
      far_jump(base, "R5");
      for (int o = 0; o < 256; o++) begin
        cyc(1'b1, 1'b0, 8'h00, 1'b0, 7'h00, 16'h0, "R2");
        cyc(1'b1, 1'b1, 8'(o), 1'b0, 7'h00, 16'h0, "R3");
      end
    end

    // R5 then R2: odd and even long-jump targets, then stepping keeps bit 0
    for (int k = 0; k < 24; k++) begin
      logic [22:0] t;
      t = 23'((k * 23'h05B3C7) ^ (k << 19)) | 23'(k & 1);
      far_jump(t, "R5");
      for (int s = 0; s < 3; s++) cyc(1'b1, 1'b0, 8'h00, 1'b0, 7'h00, 16'h0, "R2");
    end

    // R8: wrap from the top word, odd and even
    far_jump(23'h7FFFFF, "R5");
    cyc(1'b1, 1'b0, 8'h00, 1'b0, 7'h00, 16'h0, "R8");
    check("R8", pc_o, 23'h000001);
    far_jump(23'h7FFFFC, "R5");
    cyc(1'b1, 1'b0, 8'h00, 1'b0, 7'h00, 16'h0, "R8");
    cyc(1'b1, 1'b0, 8'h00, 1'b0, 7'h00, 16'h0, "R8");
    check("R8", pc_o, 23'h000000);

    // R6: priorities and pending-cycle immunity
    far_jump(23'h123456, "R5");
    cyc(1'b1, 1'b1, 8'h3C, 1'b0, 7'h00, 16'h0, "R6");
    check("R6", pc_o, 23'h123478);
    cyc(1'b1, 1'b1, 8'h11, 1'b1, 7'h0A, 16'h0, "R6");
    check("R6", {22'd0, far_pend_o}, 23'd1);
    cyc(1'b1, 1'b1, 8'h22, 1'b1, 7'h33, 16'hBEEF, "R6");
    check("R6", pc_o, {7'h0A, 16'hBEEF});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule